// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block answers a display auxiliary-channel controller at register level, for the narrow case in which the channel carries I2C traffic to a monitor's EDID device. Software fills the first data word with a request: a command nibble, a 16-bit I2C address and, in the control register, a message length. It then writes the control register with the send/busy bit set. In the same clock edge the block decodes the request and updates its I2C selection state. It also writes back a completed control value and an acknowledged reply word, so no request is ever left outstanding.

A 3-byte message carries only an address. It starts the EDID device, stops it, or resets the selection. A 4-byte read message returns one EDID byte from a 128-byte store and advances the read pointer. Write messages are acknowledged and otherwise ignored. The EDID store is loaded through its own byte port. Two inputs, monitor-present and monitor-is-DisplayPort, together with the caller's port number, decide whether EDID data may be served.

Top module: `aux_edid_responder`

## Requirements
- R1: Register offsets decode from the low address byte. 0x10 is control, and 0x14, 0x18, 0x1C, 0x20 and 0x24 are data words 1 to 5. A write to a data word stores the value, which reads back unchanged. Any other offset reads as zero.
- R2: A control write with bit 31 (send/busy) clear changes no register and no selection state.
- R3: A control write with bit 31 set replaces the control register with bit 30 (done) set and a reply size in bits 24:20. The reply size is 2 when bit 28 of data word 1 is 1 (read) and 1 when it is 0 (write). All other control bits are zero.
- R4: With length 3 (control bits 24:20) and bit 30 of data word 1 (middle-of-transaction) clear, the selection is cleared. That means not selected, EDID unavailable, pointer zero and port zero.
- R5: With length 3, middle-of-transaction set and address (data word 1 bits 23:8) equal to zero, the selection is cleared as in R4.
- R6: With length 3, middle-of-transaction set and address 0x50, the device becomes selected and the port input is recorded. EDID becomes available only if a monitor is present and is DisplayPort; otherwise availability keeps its old value.
- R7: Every processed request other than a read of a length other than 3 or 4 writes data word 1 with the ACK code 0x00 in bits 31:24 and zero in bits 15:0. For address-only and write requests, bits 23:16 are also zero.
- R8: A length-4 read while selected and available, with a monitor present and the pointer below 128, returns the EDID byte at the pointer in data word 1 bits 23:16 and advances the pointer by one.
- R9: A length-4 read while not selected or not available returns 0xFF in bits 23:16 and leaves the pointer unchanged.
- R10: A read request whose length is neither 3 nor 4 leaves data word 1 unchanged.
- R11: A length-4 read while selected and available, but with the pointer at 128 or no monitor present, returns 0x00 and does not advance the pointer.
- R12: After reset all six registers read zero, and the selection state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| store_wr_en | input | 1 | EDID store byte write strobe |
| store_wr_idx | input | 7 | EDID store byte index |
| store_wr_byte | input | 8 | EDID store byte value |
| mon_present | input | 1 | A monitor is attached |
| mon_is_dp | input | 1 | The attached monitor is DisplayPort |
| port_in | input | 2 | Port number of the requesting channel |
| sel_active | output | 1 | EDID device is selected |
| edid_ready | output | 1 | EDID data may be served |
| sel_port | output | 2 | Port recorded at the last EDID start |

## Verification
The hardest state to reach from the ports is the end of the store. Getting there takes a start, then 128 consecutive successful reads with the monitor held present, and only then a read that must return 0x00 without moving the pointer. A directed walk builds exactly that sequence. A constrained random phase mixes starts, stops, address resets, odd lengths and monitor toggles, so that reads are also seen with the device deselected, with availability stuck low, and with the monitor removed mid-walk.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

    localparam int CTL_BUSY_BIT = 31;
    localparam int CTL_DONE_BIT = 30;
    localparam int LEN_LSB      = 20;
    localparam int LEN_W        = 5;
    localparam logic [7:0] ACK_CODE = 8'h00;

    typedef enum logic [2:0] {
        RG_CTL, RG_D1, RG_D2, RG_D3, RG_D4, RG_D5, RG_NONE
    } reg_sel_e;

    typedef enum logic [2:0] {
        ACT_CLEAR,      // stop or address reset
        ACT_START,      // EDID device start
        ACT_ACK,        // acknowledged, no state change
        ACT_READ,       // single byte read
        ACT_BAD_READ    // read of unsupported length
    } req_act_e;

    typedef struct packed {
        req_act_e act;
        logic     is_read;
    } req_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            8'h10:   return RG_CTL;
            8'h14:   return RG_D1;
            8'h18:   return RG_D2;
            8'h1C:   return RG_D3;
            8'h20:   return RG_D4;
            8'h24:   return RG_D5;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic req_t decode_req(input logic [LEN_W-1:0] len,
                                        input logic [3:0]       cmd,
                                        input logic [15:0]      addr,
                                        input logic [15:0]      dev_addr);
        req_t r;
        r.is_read = cmd[0];
        if (len == LEN_W'(3)) begin
            if (!cmd[2] || addr == 16'h0) r.act = ACT_CLEAR;
            else if (addr == dev_addr)    r.act = ACT_START;
            else                          r.act = ACT_ACK;
        end else if (!cmd[0]) begin
            r.act = ACT_ACK;
        end else if (len == LEN_W'(4)) begin
            r.act = ACT_READ;
        end else begin
            r.act = ACT_BAD_READ;
        end
        return r;
    endfunction

endpackage

// File: rtl/edid_store.sv
module edid_store #(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rbyte
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wbyte;
    end

    assign rbyte = mem[ridx];
endmodule

// File: rtl/aux_req_decode.sv
module aux_req_decode
    import aux_edid_pkg::*;
#(
    parameter logic [15:0] DEV_ADDR = 16'h0050
) (
    input  logic [LEN_W-1:0] len,
    input  logic [3:0]       cmd,
    input  logic [15:0]      addr,
    output req_t             req
);
    always_comb req = decode_req(len, cmd, addr, DEV_ADDR);
endmodule

// File: rtl/aux_i2c_sel.sv
module aux_i2c_sel
    import aux_edid_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int PORT_W = 2,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  req_act_e          act,
    input  logic [PORT_W-1:0] port_in,
    input  logic              mon_present,
    input  logic              mon_is_dp,
    input  logic [7:0]        store_byte,
    output logic              sel_active,
    output logic              edid_ready,
    output logic [PORT_W-1:0] sel_port,
    output logic [PTR_W-1:0]  ptr,
    output logic [7:0]        reply_byte
);
    logic in_range;
    logic can_serve;

    assign in_range  = ptr < PTR_W'(DEPTH);
    assign can_serve = sel_active && edid_ready;

    always_comb begin
        if (!can_serve)                   reply_byte = 8'hFF;
        else if (!in_range || !mon_present) reply_byte = 8'h00;
        else                              reply_byte = store_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_active <= 1'b0;
            edid_ready <= 1'b0;
            sel_port   <= '0;
            ptr        <= '0;
        end else if (fire) begin
            case (act)
                ACT_CLEAR: begin
                    sel_active <= 1'b0;
                    edid_ready <= 1'b0;
                    sel_port   <= '0;
                    ptr        <= '0;
                end
                ACT_START: begin
                    sel_active <= 1'b1;
                    sel_port   <= port_in;
                    if (mon_present && mon_is_dp) edid_ready <= 1'b1;
                end
                ACT_READ: begin
                    if (can_serve && in_range && mon_present) ptr <= ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_ptr_bound_r11: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(DEPTH));

    p_ready_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
        edid_ready |-> sel_active);

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_CLEAR) |=> (!sel_active && !edid_ready && ptr == '0));

    p_deselected_read_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_READ && !can_serve) |=> $stable(ptr));
endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int          DEPTH    = 128,
    parameter int          PORT_W   = 2,
    parameter logic [15:0] DEV_ADDR = 16'h0050,
    localparam int         IDX_W    = $clog2(DEPTH),
    localparam int         PTR_W    = IDX_W + 1,
    localparam int         NDATA    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [7:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic              store_wr_en,
    input  logic [IDX_W-1:0]  store_wr_idx,
    input  logic [7:0]        store_wr_byte,
    input  logic              mon_present,
    input  logic              mon_is_dp,
    input  logic [PORT_W-1:0] port_in,
    output logic              sel_active,
    output logic              edid_ready,
    output logic [PORT_W-1:0] sel_port
);
    logic [31:0] ctl_q;
    logic [31:0] data_q [NDATA];

    reg_sel_e    wsel;
    reg_sel_e    rsel;
    logic        fire;
    req_t        req;
    logic [PTR_W-1:0] ptr;
    logic [7:0]  store_byte;
    logic [7:0]  reply_byte;
    logic [31:0] reply_word;

    assign wsel = decode_offset(reg_wr_addr);
    assign rsel = decode_offset(reg_rd_addr);
    assign fire = reg_wr_en && wsel == RG_CTL && reg_wr_data[CTL_BUSY_BIT];

    aux_req_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .len  (reg_wr_data[LEN_LSB +: LEN_W]),
        .cmd  (data_q[0][31:28]),
        .addr (data_q[0][23:8]),
        .req  (req)
    );

    edid_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (store_wr_en),
        .widx  (store_wr_idx),
        .wbyte (store_wr_byte),
        .ridx  (ptr[IDX_W-1:0]),
        .rbyte (store_byte)
    );

    aux_i2c_sel #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .act         (req.act),
        .port_in     (port_in),
        .mon_present (mon_present),
        .mon_is_dp   (mon_is_dp),
        .store_byte  (store_byte),
        .sel_active  (sel_active),
        .edid_ready  (edid_ready),
        .sel_port    (sel_port),
        .ptr         (ptr),
        .reply_byte  (reply_byte)
    );

    always_comb begin
        reply_word = {ACK_CODE, 24'h0};
        if (req.act == ACT_READ) reply_word[23:16] = reply_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (fire) begin
            ctl_q <= '0;
            ctl_q[CTL_DONE_BIT] <= 1'b1;
            ctl_q[LEN_LSB +: LEN_W] <= req.is_read ? LEN_W'(2) : LEN_W'(1);
        end
    end

    // data word 1 is also the reply target of a processed request
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q[0] <= '0;
        end else if (fire) begin
            if (req.act != ACT_BAD_READ) data_q[0] <= reply_word;
        end else if (reg_wr_en && wsel == RG_D1) begin
            data_q[0] <= reg_wr_data;
        end
    end

    for (genvar g = 1; g < NDATA; g++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst)                                         data_q[g] <= '0;
            else if (reg_wr_en && wsel == reg_sel_e'(g + 1)) data_q[g] <= reg_wr_data;
        end
    end

    always_comb begin
        case (rsel)
            RG_CTL:  reg_rd_data = ctl_q;
            RG_D1:   reg_rd_data = data_q[0];
            RG_D2:   reg_rd_data = data_q[1];
            RG_D3:   reg_rd_data = data_q[2];
            RG_D4:   reg_rd_data = data_q[3];
            RG_D5:   reg_rd_data = data_q[4];
            default: reg_rd_data = '0;
        endcase
    end

    p_idle_ctl_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && wsel == RG_CTL && !reg_wr_data[CTL_BUSY_BIT])
        |=> ($stable(ctl_q) && $stable(data_q[0]) && $stable(ptr)));

    p_done_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> ctl_q[CTL_DONE_BIT] && !ctl_q[CTL_BUSY_BIT]);

    p_ack_code_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && req.act != ACT_BAD_READ) |=> data_q[0][31:24] == ACK_CODE
                                               && data_q[0][15:0] == 16'h0);

    p_bad_read_r10: assert property (@(posedge clk) disable iff (rst)
        (fire && req.act == ACT_BAD_READ) |=> $stable(data_q[0]));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        !(fire && req.act == ACT_CLEAR) |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));
endmodule

// File: tb/test_aux_edid_responder.sv
module test_aux_edid_responder;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic [7:0]  reg_rd_addr;
    logic [31:0] reg_rd_data;
    logic        store_wr_en;
    logic [6:0]  store_wr_idx;
    logic [7:0]  store_wr_byte;
    logic        mon_present;
    logic        mon_is_dp;
    logic [1:0]  port_in;
    logic        sel_active;
    logic        edid_ready;
    logic [1:0]  sel_port;

    always #5 clk = ~clk;

    aux_edid_responder i_aux_edid_responder (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0]  m_mem [DEPTH];
    bit          m_sel, m_rdy;
    logic [1:0]  m_port;
    int          m_ptr;
    logic [31:0] m_d1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic m_clear();
        m_sel = 0; m_rdy = 0; m_port = 0; m_ptr = 0;
    endtask

    function automatic logic [31:0] exp_ctl(input bit rd);
        return (32'h1 << 30) | ((rd ? 32'd2 : 32'd1) << 20);
    endfunction

    // issue one request and check control, reply and selection
    task automatic aux_req(input logic [4:0] len, input logic [3:0] cmd,
                           input logic [15:0] addr, input string tag);
        logic [31:0] d1w, ctlw, got;
        logic [7:0]  b;
        d1w  = {cmd, 4'($urandom), addr, 8'($urandom)};
        ctlw = ($urandom & 32'h3E0F_FFFF) | 32'h8000_0000 | (32'(len) << 20);
        reg_wr(8'h14, d1w);
        m_d1 = d1w;
        if (len == 5'd3) begin
            if (!cmd[2] || addr == 16'h0) m_clear();
            else if (addr == 16'h0050) begin
                m_sel = 1; m_port = port_in;
                if (mon_present && mon_is_dp) m_rdy = 1;
            end
            m_d1 = 32'h0;
        end else if (!cmd[0]) begin
            m_d1 = 32'h0;
        end else if (len == 5'd4) begin
            if (!(m_sel && m_rdy)) b = 8'hFF;
            else if (m_ptr >= DEPTH || !mon_present) b = 8'h00;
            else begin b = m_mem[m_ptr]; m_ptr++; end
            m_d1 = {8'h00, b, 16'h0};
        end
        reg_wr(8'h10, ctlw);
        reg_rd(8'h10, got); chk({"R3 ctl ", tag}, got, exp_ctl(cmd[0]));
        reg_rd(8'h14, got); chk({"R7/R8/R9/R10 reply ", tag}, got, m_d1);
        chk({"R4/R5/R6 sel ", tag}, {29'h0, sel_active, edid_ready, 1'b0}, {29'h0, m_sel, m_rdy, 1'b0});
        chk({"R6 port ", tag}, {30'h0, sel_port}, {30'h0, m_port});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, prev;
        void'($urandom(32'd24681));
        rst = 1; reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0; reg_rd_addr = 0;
        store_wr_en = 0; store_wr_idx = 0; store_wr_byte = 0;
        mon_present = 1; mon_is_dp = 1; port_in = 2'd1;
        m_clear(); m_d1 = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R12 reset state
        for (int i = 0; i < 6; i++) begin
            reg_rd(8'h10 + 8'(4 * i), got); chk("R12 reg after reset", got, 32'h0);
        end
        chk("R12 selection after reset", {29'h0, sel_active, edid_ready, 1'b0}, 32'h0);

        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            m_mem[i] = 8'($urandom);
            store_wr_en = 1; store_wr_idx = 7'(i); store_wr_byte = m_mem[i];
        end
        @(negedge clk); store_wr_en = 0;

        // R1 data words and unmapped offsets
        for (int i = 1; i < 6; i++) begin
            prev = $urandom;
            reg_wr(8'h10 + 8'(4 * i), prev);
            reg_rd(8'h10 + 8'(4 * i), got); chk("R1 data store", got, prev);
        end
        reg_wr(8'h28, 32'hDEAD_BEEF);
        reg_rd(8'h28, got); chk("R1 unmapped reads zero", got, 32'h0);
        reg_rd(8'h0C, got); chk("R1 unmapped reads zero", got, 32'h0);

        // R2 busy clear leaves everything
        reg_rd(8'h14, prev);
        reg_wr(8'h10, 32'h7FFF_FFFF);
        reg_rd(8'h10, got); chk("R2 ctl unchanged", got, 32'h0);
        reg_rd(8'h14, got); chk("R2 data1 unchanged", got, prev);

        // R9 read before selection
        aux_req(5'd4, 4'h5, 16'h0050, "read unselected");
        // R6 start with DP monitor, walk to end (R8, R11)
        port_in = 2'd2;
        aux_req(5'd3, 4'h4, 16'h0050, "start");
        for (int i = 0; i < DEPTH; i++) aux_req(5'd4, 4'h5, 16'h0050, "walk");
        aux_req(5'd4, 4'h5, 16'h0050, "R11 past end");
        aux_req(5'd4, 4'h1, 16'h0050, "R11 past end again");
        // R10 odd read length
        aux_req(5'd2, 4'h5, 16'h0050, "R10 len2");
        aux_req(5'd7, 4'h1, 16'h0050, "R10 len7");
        // R7 write ack
        aux_req(5'd4, 4'h4, 16'h0050, "R7 write len4");
        // R4 stop
        aux_req(5'd3, 4'h1, 16'h0050, "R4 stop");
        // R6 non-DP start: selected but not available
        mon_is_dp = 0;
        aux_req(5'd3, 4'h4, 16'h0050, "R6 start non-dp");
        aux_req(5'd4, 4'h5, 16'h0050, "R9 read unavailable");
        // R5 address reset
        aux_req(5'd3, 4'h4, 16'h0000, "R5 addr zero");
        // R11 monitor gone mid-read
        mon_is_dp = 1;
        aux_req(5'd3, 4'h4, 16'h0050, "restart");
        mon_present = 0;
        aux_req(5'd4, 4'h5, 16'h0050, "R11 no monitor");
        mon_present = 1;
        aux_req(5'd4, 4'h5, 16'h0050, "R8 resume");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0]  len;
            logic [15:0] a;
            int k;
            k = int'($urandom % 8);
            len = (k < 3) ? 5'd3 : (k < 7) ? 5'd4 : 5'($urandom);
            k = int'($urandom % 4);
            a = (k == 0) ? 16'h0 : (k == 3) ? 16'($urandom) : 16'h0050;
            if ($urandom % 10 == 0) mon_present = ~mon_present;
            if ($urandom % 10 == 0) mon_is_dp   = ~mon_is_dp;
            port_in = 2'($urandom);
            aux_req(len, 4'($urandom), a, "random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule